// File: doc/BRIEF.md
# Segmented Store Protection Checker

This block sits beside a RAM port and screens every store against a small set of programmable address windows (two by default). Each window has a start word address, an end word address and an enable pair that arms it separately for user-class and supervisor-class data stores. A global mode input selects between two rules: blocking stores that land inside an armed window, or permitting stores only when they land inside one.

The decision is combinational. A store presented with its byte address, a doubleword flag and its access class yields an allow or a fault strobe in the same cycle, so the RAM write enable can be gated directly by the allow output. Window registers are loaded through a simple write port. Writes that set bits outside the defined fields raise a one-cycle parity-error strobe.

Top module: `seg_wprot`

## Requirements
- R1: `cfg_idx` selects a register: bit 0 chooses start (0) or end (1), the upper bits choose the window. A start read returns the start word address in bits 22:0 and the enable pair in bits 24:23, with zeros above. An end read returns the end word address in bits 22:0. A write takes effect from the next clock edge.
- R2: The word address of a store is byte address bits 22:2. Byte address bits 31:23 and 1:0 do not affect the decision.
- R3: A window is hit when its enable bit for the store's class is set, the word address is at or above the start, and the word address is below the end. Enable bit 0 arms user stores (`st_super`=0) and bit 1 arms supervisor stores (`st_super`=1).
- R4: For a doubleword store (`st_dword`=1), bit 0 of the word address is forced to 1 before the end comparison.
- R5: With `blk_mode`=1, a store that hits any window is denied and all others are allowed.
- R6: With `blk_mode`=0, a store is denied when it hits no window, but only while at least one enable bit of any window is set. When all enables are zero every store is allowed.
- R7: A write with a nonzero bit in 31:25 of a start register, or in 31:23 of an end register, raises `cfg_perr` for exactly the following cycle. The defined fields are stored anyway, and the undefined bits read back as zero.
- R8: When `st_valid`=1 exactly one of `st_allow` and `fault_strb` is high, in the same cycle as the request. When `st_valid`=0 both are low.
- R9: Synchronous reset clears every register to zero and clears `cfg_perr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 2 | Register select (bit 0 start/end, upper bits window) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| cfg_perr | output | 1 | Parity-error strobe for an illegal write |
| blk_mode | input | 1 | 1: deny inside windows, 0: allow only inside windows |
| st_valid | input | 1 | Store request present |
| st_addr | input | 32 | Store byte address |
| st_dword | input | 1 | Store is a doubleword |
| st_super | input | 1 | Store class: 1 supervisor, 0 user |
| st_allow | output | 1 | Store may be written |
| fault_strb | output | 1 | Store denied, protection fault |

## Verification
The bench builds the block with its default of two windows, which makes the full register index range reachable and lets one window be armed for user stores while the other is armed for supervisor stores. With both windows live, the class-selection path, the overlap-free hit in each window and the doubleword end boundary on an odd end address can all be exercised under both rule modes. The 32-bit address width lets the bench set high address bits to show that they are ignored.

// File: rtl/seg_wprot_pkg.sv
package seg_wprot_pkg;

    localparam int DW   = 32;   // register and address width
    localparam int WA_W = 23;   // word address field width
    localparam int EN_W = 2;    // per-window enable pair

    typedef enum logic {
        ACC_USER  = 1'b0,
        ACC_SUPER = 1'b1
    } acc_t;

    typedef struct packed {
        logic [EN_W-1:0] en;
        logic [WA_W-1:0] lo;
        logic [WA_W-1:0] hi;
    } seg_cfg_t;

    // Word address: byte bits 22:2, zero-extended to the field width.
    function automatic logic [WA_W-1:0] word_of(input logic [DW-1:0] byte_addr);
        return WA_W'(byte_addr[WA_W-1:2]);
    endfunction

endpackage

// File: rtl/seg_wprot_regs.sv
module seg_wprot_regs
    import seg_wprot_pkg::*;
#(
    parameter  int NSEG  = 2,
    localparam int SEL_W = (NSEG > 1) ? $clog2(NSEG) : 1,
    localparam int IDX_W = SEL_W + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [IDX_W-1:0]     idx,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    output logic                 perr,
    output seg_cfg_t [NSEG-1:0]  cfg
);

    localparam int START_TOP = WA_W + EN_W;

    logic [SEL_W-1:0] seg_sel;
    logic             is_end;
    logic             bad_bits;

    assign seg_sel = idx[IDX_W-1:1];
    assign is_end  = idx[0];

    always_comb begin
        if (is_end) bad_bits = |wdata[DW-1:WA_W];
        else        bad_bits = |wdata[DW-1:START_TOP];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            perr <= 1'b0;
        end else begin
            perr <= we && bad_bits;
            if (we && (int'(seg_sel) < NSEG)) begin
                if (is_end) begin
                    cfg[seg_sel].hi <= wdata[WA_W-1:0];
                end else begin
                    cfg[seg_sel].lo <= wdata[WA_W-1:0];
                    cfg[seg_sel].en <= wdata[START_TOP-1:WA_W];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(seg_sel) < NSEG) begin
            if (is_end) rdata = DW'(cfg[seg_sel].hi);
            else        rdata = DW'({cfg[seg_sel].en, cfg[seg_sel].lo});
        end
    end

    // R7
    perr_chk: assert property (@(posedge clk) disable iff (rst)
        perr |-> $past(we));

    // R7
    perr_src_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> !perr);

endmodule

// File: rtl/seg_wprot_cmp.sv
module seg_wprot_cmp
    import seg_wprot_pkg::*;
(
    input  seg_cfg_t         cfg,
    input  logic [WA_W-1:0]  waddr,
    input  logic             dword,
    input  acc_t             acc,
    output logic             hit
);

    logic             armed;
    logic [WA_W-1:0]  tail;

    always_comb begin
        armed = cfg.en[acc];
        tail  = waddr | WA_W'(dword);
        hit   = armed && (waddr >= cfg.lo) && (tail < cfg.hi);
    end

endmodule

// File: rtl/seg_wprot.sv
module seg_wprot
    import seg_wprot_pkg::*;
#(
    parameter  int NSEG  = 2,
    localparam int SEL_W = (NSEG > 1) ? $clog2(NSEG) : 1,
    localparam int IDX_W = SEL_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    output logic              cfg_perr,
    input  logic              blk_mode,
    input  logic              st_valid,
    input  logic [DW-1:0]     st_addr,
    input  logic              st_dword,
    input  logic              st_super,
    output logic              st_allow,
    output logic              fault_strb
);

    seg_cfg_t [NSEG-1:0] cfg;
    logic     [NSEG-1:0] hit;
    logic     [NSEG-1:0] seg_armed;
    logic     [WA_W-1:0] waddr;
    acc_t                acc;
    logic                any_hit;
    logic                any_armed;
    logic                deny;

    seg_wprot_regs #(.NSEG(NSEG)) regs_i (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .idx   (cfg_idx),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .perr  (cfg_perr),
        .cfg   (cfg)
    );

    assign waddr = word_of(st_addr);
    assign acc   = st_super ? ACC_SUPER : ACC_USER;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        seg_wprot_cmp cmp_i (
            .cfg   (cfg[g]),
            .waddr (waddr),
            .dword (st_dword),
            .acc   (acc),
            .hit   (hit[g])
        );
        assign seg_armed[g] = |cfg[g].en;
    end

    assign any_hit   = |hit;
    assign any_armed = |seg_armed;

    always_comb begin
        if (blk_mode) deny = any_hit;
        else          deny = any_armed && !any_hit;
        st_allow   = st_valid && !deny;
        fault_strb = st_valid && deny;
    end

    // R8
    excl_chk: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> (st_allow != fault_strb));

    // R8
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !st_valid |-> (!st_allow && !fault_strb));

    // R6
    open_chk: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !blk_mode && !any_armed) |-> st_allow);

    // R5
    blk_chk: assert property (@(posedge clk) disable iff (rst)
        (st_valid && blk_mode && any_hit) |-> fault_strb);

    // R6
    inside_chk: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !blk_mode && any_hit) |-> st_allow);

endmodule

// File: tb/seg_wprot_tb.sv
module seg_wprot_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_idx;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        cfg_perr;
    logic        blk_mode;
    logic        st_valid;
    logic [31:0] st_addr;
    logic        st_dword;
    logic        st_super;
    logic        st_allow;
    logic        fault_strb;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    seg_wprot dut_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cfg_perr   (cfg_perr),
        .blk_mode   (blk_mode),
        .st_valid   (st_valid),
        .st_addr    (st_addr),
        .st_dword   (st_dword),
        .st_super   (st_super),
        .st_allow   (st_allow),
        .fault_strb (fault_strb)
    );

    // Vector: {blk_mode, super, dword, expect_allow, byte_addr}
    // Window 0: words 0x100..0x1FF, user only. Window 1: words 0x400..0x480, supervisor only.
    localparam int NV = 19;
    localparam logic [35:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0400},  // user at window 0 start
        {1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_07FC},  // user at last word
        {1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0800},  // user at end (excluded)
        {1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_03FC},  // user below start
        {1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_07F8},  // user dword fits
        {1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0400},  // super in user window
        {1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_1000},  // super at window 1 start
        {1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_1200},  // super at word 0x480
        {1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_1200},  // super dword crosses odd end
        {1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_1204},  // super at end
        {1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_1000},  // user in super window
        {1'b0, 1'b0, 1'b0, 1'b1, 32'h0200_0400},  // high bits ignored
        {1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0403},  // low bits ignored
        {1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_0400},  // block: user hit
        {1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_0800},  // block: user miss
        {1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_0400},  // block: super not armed in w0
        {1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_1100},  // block: super hit
        {1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_1200},  // block: dword out of range
        {1'b1, 1'b0, 1'b0, 1'b0, 32'h0080_0400}   // block: bit 23 ignored, hit
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] idx, input logic [31:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_idx   = idx;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic reg_read(input string req, input logic [1:0] idx, input logic [31:0] exp);
        @(negedge clk);
        cfg_idx = idx;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    task automatic store(input logic mode, input logic sup, input logic dw, input logic [31:0] a);
        @(negedge clk);
        blk_mode = mode;
        st_valid = 1'b1;
        st_super = sup;
        st_dword = dw;
        st_addr  = a;
        #1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
        blk_mode = 1'b0; st_valid = 1'b0; st_addr = '0; st_dword = 1'b0; st_super = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        for (int i = 0; i < 4; i++) reg_read("R9 reset register", 2'(i), 32'h0);
        chk("R9 reset perr", {31'b0, cfg_perr}, 32'h0);

        // R8 idle
        @(negedge clk);
        st_valid = 1'b0;
        #1;
        chk("R8 idle allow", {31'b0, st_allow}, 32'h0);
        chk("R8 idle fault", {31'b0, fault_strb}, 32'h0);

        // R6 nothing armed
        store(1'b0, 1'b0, 1'b0, 32'h0000_0800);
        chk("R6 unarmed allow", {31'b0, st_allow}, 32'h1);
        st_valid = 1'b0;

        // R1 configure windows and read back
        reg_write(2'd0, 32'h0080_0100);
        reg_write(2'd1, 32'h0000_0200);
        reg_write(2'd2, 32'h0100_0400);
        reg_write(2'd3, 32'h0000_0481);
        reg_read("R1 start0 readback", 2'd0, 32'h0080_0100);
        reg_read("R1 end0 readback",   2'd1, 32'h0000_0200);
        reg_read("R1 start1 readback", 2'd2, 32'h0100_0400);
        reg_read("R1 end1 readback",   2'd3, 32'h0000_0481);

        // R2 R3 R4 R5 R6 R8 vector walk
        for (int v = 0; v < NV; v++) begin
            store(VEC[v][35], VEC[v][34], VEC[v][33], VEC[v][31:0]);
            chk($sformatf("R2 R3 R4 R5 R6 vector %0d allow", v), {31'b0, st_allow}, {31'b0, VEC[v][32]});
            chk($sformatf("R8 vector %0d fault", v), {31'b0, fault_strb}, {31'b0, ~VEC[v][32]});
        end
        @(negedge clk);
        st_valid = 1'b0;

        // R7 parity strobe on illegal bits
        reg_write(2'd0, 32'h0280_0100);
        chk("R7 start perr", {31'b0, cfg_perr}, 32'h1);
        reg_read("R7 start masked", 2'd0, 32'h0080_0100);
        chk("R7 perr one cycle", {31'b0, cfg_perr}, 32'h0);
        reg_write(2'd1, 32'h0080_0200);
        chk("R7 end perr", {31'b0, cfg_perr}, 32'h1);
        reg_read("R7 end masked", 2'd1, 32'h0000_0200);
        reg_write(2'd1, 32'h0000_0200);
        chk("R7 legal no perr", {31'b0, cfg_perr}, 32'h0);

        // R6 disarm all windows: non-block mode opens everything
        reg_write(2'd0, 32'h0000_0100);
        reg_write(2'd2, 32'h0000_0400);
        store(1'b0, 1'b0, 1'b0, 32'h0000_0800);
        chk("R6 disarmed allow", {31'b0, st_allow}, 32'h1);
        store(1'b1, 1'b1, 1'b0, 32'h0000_1100);
        chk("R5 disarmed block allow", {31'b0, st_allow}, 32'h1);
        @(negedge clk);
        st_valid = 1'b0;

        // R9 reset mid-run
        reg_write(2'd0, 32'h0080_0100);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        reg_read("R9 start0 after reset", 2'd0, 32'h0);
        reg_read("R9 end1 after reset", 2'd3, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule